// File: doc/BRIEF.md
# Left-to-Right Modular Exponentiation Sequencer

This block computes `result = msg ^ expo mod modulus` for operands of a configurable width `K`. The default is 1024 bits, and the bench uses small widths. The block does not multiply anything itself. It steers an external modular multiplier through a one-cycle `mul_start` pulse and a one-cycle `mul_done` reply, and it places the accumulator and the second operand on `mul_a`/`mul_b`. Encryption and decryption use the same hardware. The caller loads either the public or the private exponent.

The exponent is scanned from its most significant bit downward. The top bit is consumed when the accumulator is seeded. It is seeded with the message if that bit is one, and with the value 1 otherwise. Each remaining bit causes one squaring. A one bit then causes a multiplication by the message, and a zero bit skips that multiplication.

The controller states are:
- `ST_IDLE`: waits for `start`, then latches the operands and goes to `ST_SQ_ISSUE`.
- `ST_SQ_ISSUE`: pulses `mul_start` with the accumulator on both operands, then goes to `ST_SQ_WAIT`.
- `ST_SQ_WAIT`: on `mul_done` it stores the product. It goes to `ST_MUL_ISSUE` when the current bit is 1. Otherwise it advances the scan and goes to `ST_FINISH` if this was bit 0, or back to `ST_SQ_ISSUE` if not.
- `ST_MUL_ISSUE`: pulses `mul_start` with the message as second operand, then goes to `ST_MUL_WAIT`.
- `ST_MUL_WAIT`: on `mul_done` it stores the product, advances the scan, and goes to `ST_FINISH` or `ST_SQ_ISSUE`.
- `ST_FINISH`: raises `done` for one cycle and returns to `ST_IDLE`.

Top module: `modexp_lr`

## Requirements
- R1: When `done` is high, `result` equals `msg^expo mod modulus` for the operands that were present when the accepted `start` was sampled.
- R2: The accumulator is seeded from the top exponent bit: `msg` if `expo[K-1]` is 1, else 1. The top bit is never squared again, so `expo = 2^(K-1)` yields `msg^(2^(K-1)) mod modulus`.
- R3: One run issues exactly `(K-1) + popcount(expo[K-2:0])` multiplier operations.
- R4: Every issued operation has the accumulator on `mul_a`. `mul_b` is either the accumulator (square) or the latched message (multiply), and `mul_n` is the latched modulus.
- R5: At most one multiplier operation is outstanding. `mul_start` is never raised before the `mul_done` of the previous operation.
- R6: `done` is high for exactly one cycle per run.
- R7: A `start` that arrives while a run is in progress is ignored, and that run's result is unchanged.
- R8: An exponent of zero yields 1, given `modulus > 1`.
- R9: After synchronous reset, `done` and `mul_start` are low.
- R10: `mul_a`, `mul_b` and `mul_n` stay stable while an operation is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run when idle |
| msg | input | K | Base, expected below `modulus` |
| expo | input | K | Exponent |
| modulus | input | K | Modulus |
| result | output | K | Accumulator, final when `done` |
| done | output | 1 | One-cycle completion pulse |
| mul_start | output | 1 | Issue one modular multiply |
| mul_a | output | K | Multiplier first operand |
| mul_b | output | K | Multiplier second operand |
| mul_n | output | K | Multiplier modulus |
| mul_done | input | 1 | Multiplier completion pulse |
| mul_prod | input | K | Multiplier product, valid with `mul_done` |

## Verification
The checks assume a multiplier that raises `mul_done` only for an operation it has accepted, always after at least one cycle. They also assume that `mul_prod` is already reduced and that `msg < modulus` with `modulus > 1`. The bench models the multiplier with a random latency of one to four cycles. It draws the modulus from 2 upward and the message below it. Directed cases add exponent zero, exponent one, a top-bit-only exponent, an all-ones exponent, a zero message, and a second `start` injected in the middle of a run.

// File: rtl/modexp_pkg.sv
package modexp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SQ_ISSUE,
        ST_SQ_WAIT,
        ST_MUL_ISSUE,
        ST_MUL_WAIT,
        ST_FINISH
    } mx_state_e;
endpackage

// File: rtl/mx_bit_scanner.sv
// Holds the exponent and presents one bit per step, most significant first.
module mx_bit_scanner #(
    parameter int K = 1024
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [K-1:0] exp_in,
    input  logic         step,
    output logic         top_bit,
    output logic         cur_bit,
    output logic         last
);
    localparam int CW = $clog2(K);

    logic [K-1:0]  sh_q;
    logic [CW-1:0] cnt_q;

    // The top bit is consumed by seeding, so scanning starts one below it.
    assign top_bit = exp_in[K-1];
    assign cur_bit = sh_q[K-1];
    assign last    = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= {exp_in[K-2:0], 1'b0};
            cnt_q <= CW'(K - 2);
        end else if (step) begin
            sh_q  <= {sh_q[K-2:0], 1'b0};
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/mx_accum.sv
// Accumulator plus the latched message and modulus used for every operation.
module mx_accum #(
    parameter int K = 1024
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init,
    input  logic         seed_msg,
    input  logic [K-1:0] msg_in,
    input  logic [K-1:0] mod_in,
    input  logic         capture,
    input  logic [K-1:0] prod_in,
    input  logic         sel_msg,
    output logic [K-1:0] acc,
    output logic [K-1:0] opnd_b,
    output logic [K-1:0] mod_q
);
    logic [K-1:0] acc_q;
    logic [K-1:0] msg_q;
    logic [K-1:0] mod_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            msg_q <= '0;
            mod_r <= '0;
        end else if (init) begin
            msg_q <= msg_in;
            mod_r <= mod_in;
            acc_q <= seed_msg ? msg_in : K'(1);
        end else if (capture) begin
            acc_q <= prod_in;
        end
    end

    assign acc    = acc_q;
    assign opnd_b = sel_msg ? msg_q : acc_q;
    assign mod_q  = mod_r;
endmodule

// File: rtl/mx_ctrl.sv
// Sequencer: one square per bit, then a multiply when the bit is one.
module mx_ctrl
    import modexp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic mul_done,
    input  logic cur_bit,
    input  logic last,
    output logic load,
    output logic mul_start,
    output logic sel_msg,
    output logic capture,
    output logic step,
    output logic done
);
    mx_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = ST_SQ_ISSUE;
            ST_SQ_ISSUE:  state_d = ST_SQ_WAIT;
            ST_SQ_WAIT:   if (mul_done) begin
                              if (cur_bit)   state_d = ST_MUL_ISSUE;
                              else if (last) state_d = ST_FINISH;
                              else           state_d = ST_SQ_ISSUE;
                          end
            ST_MUL_ISSUE: state_d = ST_MUL_WAIT;
            ST_MUL_WAIT:  if (mul_done) state_d = last ? ST_FINISH : ST_SQ_ISSUE;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load      = 1'b0;
        mul_start = 1'b0;
        sel_msg   = 1'b0;
        capture   = 1'b0;
        step      = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:      load = start;
            ST_SQ_ISSUE:  mul_start = 1'b1;
            ST_SQ_WAIT:   begin
                              capture = mul_done;
                              step    = mul_done & ~cur_bit;
                          end
            ST_MUL_ISSUE: begin
                              mul_start = 1'b1;
                              sel_msg   = 1'b1;
                          end
            ST_MUL_WAIT:  begin
                              sel_msg = 1'b1;
                              capture = mul_done;
                              step    = mul_done;
                          end
            ST_FINISH:    done = 1'b1;
            default:      ;
        endcase
    end
endmodule

// File: rtl/modexp_lr.sv
module modexp_lr #(
    parameter int K = 1024
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [K-1:0] msg,
    input  logic [K-1:0] expo,
    input  logic [K-1:0] modulus,
    output logic [K-1:0] result,
    output logic         done,
    output logic         mul_start,
    output logic [K-1:0] mul_a,
    output logic [K-1:0] mul_b,
    output logic [K-1:0] mul_n,
    input  logic         mul_done,
    input  logic [K-1:0] mul_prod
);
    logic load, sel_msg, capture, step, top_bit, cur_bit, last;

    mx_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .mul_done(mul_done),
        .cur_bit(cur_bit), .last(last), .load(load), .mul_start(mul_start),
        .sel_msg(sel_msg), .capture(capture), .step(step), .done(done)
    );

    mx_bit_scanner #(.K(K)) u_scan (
        .clk(clk), .rst(rst), .load(load), .exp_in(expo), .step(step),
        .top_bit(top_bit), .cur_bit(cur_bit), .last(last)
    );

    mx_accum #(.K(K)) u_acc (
        .clk(clk), .rst(rst), .init(load), .seed_msg(top_bit),
        .msg_in(msg), .mod_in(modulus), .capture(capture), .prod_in(mul_prod),
        .sel_msg(sel_msg), .acc(result), .opnd_b(mul_b), .mod_q(mul_n)
    );

    assign mul_a = result;
endmodule

// File: rtl/modexp_lr_chk.sv
module modexp_lr_chk #(
    parameter int K = 1024
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [K-1:0] msg,
    input logic [K-1:0] modulus,
    input logic [K-1:0] result,
    input logic         done,
    input logic         mul_start,
    input logic [K-1:0] mul_a,
    input logic [K-1:0] mul_b,
    input logic [K-1:0] mul_n,
    input logic         mul_done
);
    logic         busy_q, pend_q;
    logic [K-1:0] m_q, n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            pend_q <= 1'b0;
            m_q    <= '0;
            n_q    <= '0;
        end else begin
            if (start && !busy_q) begin
                busy_q <= 1'b1;
                m_q    <= msg;
                n_q    <= modulus;
            end else if (done) begin
                busy_q <= 1'b0;
            end
            if (mul_start)     pend_q <= 1'b1;
            else if (mul_done) pend_q <= 1'b0;
        end
    end

    // R5
    one_op_chk: assert property (@(posedge clk) disable iff (rst)
        mul_start |-> !pend_q);

    // R4
    operand_chk: assert property (@(posedge clk) disable iff (rst)
        mul_start |-> (mul_a == result) && ((mul_b == mul_a) || (mul_b == m_q)) && (mul_n == n_q));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> $stable(mul_a) && $stable(mul_b) && $stable(mul_n));

    // R6
    pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    busy_chk: assert property (@(posedge clk) disable iff (rst)
        (mul_start || done) |-> busy_q);

    // R1
    quiet_end_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !pend_q && !mul_start);
endmodule

bind modexp_lr modexp_lr_chk #(.K(K)) u_chk (
    .clk(clk), .rst(rst), .start(start), .msg(msg), .modulus(modulus),
    .result(result), .done(done), .mul_start(mul_start), .mul_a(mul_a),
    .mul_b(mul_b), .mul_n(mul_n), .mul_done(mul_done)
);

// File: tb/sim_modexp_lr.sv
module sim_modexp_lr;
    localparam int K = 16;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [K-1:0] msg = '0, expo = '0, modulus = 16'd3;
    logic [K-1:0] result, mul_a, mul_b, mul_n;
    logic [K-1:0] mul_prod = '0;
    logic         done, mul_start;
    logic         mul_done = 1'b0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modexp_lr #(.K(K)) u0 (
        .clk(clk), .rst(rst), .start(start), .msg(msg), .expo(expo),
        .modulus(modulus), .result(result), .done(done), .mul_start(mul_start),
        .mul_a(mul_a), .mul_b(mul_b), .mul_n(mul_n), .mul_done(mul_done),
        .mul_prod(mul_prod)
    );

    // Behavioural multiplier with random latency of 1 to 4 cycles.
    logic         pend = 1'b0;
    int           lat = 0;
    longint       pa, pb, pn;
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            pend     <= 1'b0;
            mul_done <= 1'b0;
        end else begin
            mul_done <= 1'b0;
            if (mul_start) begin
                pa   <= longint'(mul_a);
                pb   <= longint'(mul_b);
                pn   <= longint'(mul_n);
                lat  <= 1 + int'($urandom % 4);
                pend <= 1'b1;
            end else if (pend) begin
                if (lat <= 1) begin
                    mul_done <= 1'b1;
                    mul_prod <= K'((pa * pb) % pn);
                    pend     <= 1'b0;
                end else begin
                    lat <= lat - 1;
                end
            end
        end
    end

    function automatic longint ref_pow(longint m, longint e, longint n);
        longint r = 1 % n;
        longint b = m % n;
        for (int i = 0; i < K; i++) begin
            if (e[i]) r = (r * b) % n;
            b = (b * b) % n;
        end
        return r;
    endfunction

    function automatic int ref_ops(logic [K-1:0] e);
        return (K - 1) + $countones(e[K-2:0]);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input logic [K-1:0] m, input logic [K-1:0] e,
                            input logic [K-1:0] n, input string req, input bit poke);
        int ops = 0;
        int t = 0;
        int pulses = 0;
        longint want = ref_pow(longint'(m), longint'(e), longint'(n));
        @(negedge clk);
        msg = m; expo = e; modulus = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && t < 2000) begin
            if (mul_start) ops++;
            if (poke && t == 3) begin
                msg = ~m; expo = ~e; modulus = n - 16'd1 + 16'd1; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            t++;
        end
        start = 1'b0;
        check(done == 1'b1, {req, " done seen"}, done, 1);
        check(result == K'(want), {req, " R1 result"}, result, want);
        if (!poke) check(ops == ref_ops(e), {req, " R3 op count"}, ops, ref_ops(e));
        pulses = int'(done);
        @(negedge clk);
        check(done == 1'b0, {req, " R6 single pulse"}, pulses + int'(done), 1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R9 reset state
        check(done == 1'b0, "R9 done low", done, 0);
        check(mul_start == 1'b0, "R9 mul_start low", mul_start, 0);
        rst = 1'b0;
        // R8 zero exponent
        run_case(16'd1234, 16'd0, 16'd40961, "R8 zero exponent", 1'b0);
        run_case(16'd77, 16'd1, 16'd1009, "R1 unit exponent", 1'b0);
        // R2 top-bit-only exponent
        run_case(16'd5, 16'h8000, 16'd65521, "R2 top bit only", 1'b0);
        run_case(16'd3, 16'hFFFF, 16'd65000, "R2 all ones", 1'b0);
        run_case(16'd0, 16'd9, 16'd97, "R1 zero message", 1'b0);
        run_case(16'd1, 16'd2, 16'd2, "R1 small modulus", 1'b0);
        // R7 start during a run is ignored
        run_case(16'd4321, 16'hA5C3, 16'd50021, "R7 busy start", 1'b1);
        for (int i = 0; i < 40; i++) begin
            logic [K-1:0] n = K'(2 + ($urandom % 65534));
            logic [K-1:0] m = K'($urandom % n);
            logic [K-1:0] e = K'($urandom);
            run_case(m, e, n, "R1 R3 random", 1'b0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles >= WATCHDOG);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule